// File: doc/BRIEF.md
# Four-to-one serial transmitter with word-clock divider

This block turns a stream of 4-bit words into a serial bit stream at the bit-clock rate. The most significant bit of each word leaves first. A divide-by-four counter on the bit clock produces the word-rate read clock, which paces the elastic buffer that supplies the words. The next word is taken on the bit-clock edge right after the last bit of the previous word goes out, so the output stream has no gaps.

Two more outputs serve the board. A gated copy of the bit clock is enabled or held low by a two-bit strap code. An auxiliary output can be powered down, can carry the word clock, or can carry a loopback copy of the serial data for system diagnostics. The bit clock is modelled as a single digital clock. The reset is synchronous and active high, so the word-clock phase is known once reset ends.

Top module: `ser4_tx`

## Requirements
- R1: Each accepted word is sent most significant bit first. After the load edge `ser_out` shows bit 3, and after each of the next three edges it shows bits 2, 1 and 0.
- R2: `word_in` is sampled only on load edges. The first load edge is the first edge with `rst` low, and after that there is one every 4 bit-clock edges, back to back. A change of `word_in` between load edges has no effect on `ser_out`.
- R3: Let n be the number of edges since reset ended. After edge n, `word_clk` is 1 when n mod 4 is 0 or 1, and 0 when n mod 4 is 2 or 3. It has a period of exactly 4 bit clocks and rises one edge before each load edge.
- R4: Reset is synchronous. After any edge with `rst` high, `ser_out` is 0 and `word_clk` is 1. The serial output stays 0 until the first word is loaded.
- R5: While `aux_pwr` is 0, `aux_out` is 0 and `aux_active` is 0, whatever `loop_en` is.
- R6: While `aux_pwr` is 1 and `loop_en` is 0, `aux_active` is 1 and `aux_out` equals `word_clk`.
- R7: While `aux_pwr` is 1 and `loop_en` is 1, `aux_active` is 1 and `aux_out` equals `ser_out`.
- R8: For `clk_mode` 2'b00 (strapped low) and 2'b11 (strapped high), `ser_clk_out` follows `clk_bit`. For 2'b01 (pulled low) and 2'b10 (floating), `ser_clk_out` is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous reset, active high |
| word_in | input | WORD_W (4) | Parallel word from the elastic buffer, bit 3 sent first |
| aux_pwr | input | 1 | Auxiliary output power, 1 = on |
| loop_en | input | 1 | Auxiliary source select: 1 = serial data, 0 = word clock |
| clk_mode | input | 2 | Strap code that enables the serial clock output |
| ser_out | output | 1 | Serial data |
| ser_clk_out | output | 1 | Gated serial bit clock |
| word_clk | output | 1 | Bit clock divided by WORD_W, the buffer read clock |
| aux_out | output | 1 | Auxiliary output data |
| aux_active | output | 1 | Auxiliary driver enabled |

## Verification
Serial bits and the word clock are registered. Each one is due one bit-clock edge after the state that causes it: bit 3 of a word appears after its load edge, and the word-clock level after edge n follows n mod 4. The bench drives and samples only on falling edges, so every sample comes half a cycle after the edge that produced it. The auxiliary output and the gated clock are combinational and are checked in the same half cycle as the control that selects them. The gated clock is sampled 2 ns after a rising edge, while the bit clock is high. Words are changed only in the half cycle before a load edge, and junk words are driven between load edges to show that they are ignored.

// File: rtl/ser4_pkg.sv
package ser4_pkg;

   typedef enum logic [1:0] {
      CKM_STRAP_LOW  = 2'b00,
      CKM_PULL_LOW   = 2'b01,
      CKM_FLOAT      = 2'b10,
      CKM_STRAP_HIGH = 2'b11
   } clk_mode_e;

   typedef enum logic [1:0] {
      AUX_OFF  = 2'b00,
      AUX_WCLK = 2'b01,
      AUX_LOOP = 2'b10
   } aux_sel_e;

   // the serial clock driver runs only for the two hard-strapped codes
   function automatic logic mode_keeps_clk(input clk_mode_e m);
      return (m == CKM_STRAP_LOW) || (m == CKM_STRAP_HIGH);
   endfunction

   function automatic aux_sel_e aux_decode(input logic pwr, input logic loop);
      if (!pwr)     return AUX_OFF;
      else if (loop) return AUX_LOOP;
      else           return AUX_WCLK;
   endfunction

endpackage

// File: rtl/ser4_phase_div.sv
module ser4_phase_div #(
   parameter int WORD_W = 4
) (
   input  logic clk,
   input  logic rst,
   output logic load,
   output logic word_clk
);
   localparam int CW = (WORD_W > 2) ? $clog2(WORD_W) : 1;

   logic [CW-1:0] phase_q;

   always_ff @(posedge clk) begin
      if (rst) phase_q <= '0;
      else     phase_q <= phase_q + 1'b1;
   end

   // the phase wraps naturally because WORD_W is a power of two
   assign load     = (phase_q == '0);
   assign word_clk = ~phase_q[CW-1];
endmodule

// File: rtl/ser4_shifter.sv
module ser4_shifter #(
   parameter int WORD_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [WORD_W-1:0] word,
   output logic              ser
);
   logic [WORD_W-1:0] sh_q;

   for (genvar i = 0; i < WORD_W; i++) begin : g_cell
      logic nxt;
      if (i == 0) begin : g_tail
         assign nxt = load ? word[0] : 1'b0;
      end else begin : g_body
         assign nxt = load ? word[i] : sh_q[i-1];
      end
      always_ff @(posedge clk) begin
         if (rst) sh_q[i] <= 1'b0;
         else     sh_q[i] <= nxt;
      end
   end

   assign ser = sh_q[WORD_W-1];
endmodule

// File: rtl/ser4_aux_sel.sv
module ser4_aux_sel
   import ser4_pkg::*;
(
   input  logic pwr,
   input  logic loop,
   input  logic ser,
   input  logic wclk,
   output logic aux,
   output logic active
);
   aux_sel_e sel;

   always_comb begin
      sel    = aux_decode(pwr, loop);
      active = (sel != AUX_OFF);
      case (sel)
         AUX_LOOP: aux = ser;
         AUX_WCLK: aux = wclk;
         default:  aux = 1'b0;
      endcase
   end
endmodule

// File: rtl/ser4_clk_gate.sv
module ser4_clk_gate
   import ser4_pkg::*;
(
   input  logic       clk,
   input  logic [1:0] mode,
   output logic       clk_out
);
   logic en;

   assign en      = mode_keeps_clk(clk_mode_e'(mode));
   assign clk_out = clk & en;
endmodule

// File: rtl/ser4_tx.sv
module ser4_tx #(
   parameter int WORD_W = 4
) (
   input  logic              clk_bit,
   input  logic              rst,
   input  logic [WORD_W-1:0] word_in,
   input  logic              aux_pwr,
   input  logic              loop_en,
   input  logic [1:0]        clk_mode,
   output logic              ser_out,
   output logic              ser_clk_out,
   output logic              word_clk,
   output logic              aux_out,
   output logic              aux_active
);
   localparam bit W_POW2 = (WORD_W >= 2) && ((WORD_W & (WORD_W - 1)) == 0);

   if (!W_POW2) begin : g_bad_width
      $error("ser4_tx: WORD_W must be a power of two and at least 2");
   end

   logic load;

   ser4_phase_div #(.WORD_W(WORD_W)) u_div (
      .clk      (clk_bit),
      .rst      (rst),
      .load     (load),
      .word_clk (word_clk)
   );

   ser4_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk  (clk_bit),
      .rst  (rst),
      .load (load),
      .word (word_in),
      .ser  (ser_out)
   );

   ser4_aux_sel u_aux (
      .pwr    (aux_pwr),
      .loop   (loop_en),
      .ser    (ser_out),
      .wclk   (word_clk),
      .aux    (aux_out),
      .active (aux_active)
   );

   ser4_clk_gate u_cg (
      .clk     (clk_bit),
      .mode    (clk_mode),
      .clk_out (ser_clk_out)
   );
endmodule

// File: rtl/ser4_tx_chk.sv
module ser4_tx_chk #(
   parameter int WORD_W = 4
) (
   input logic              clk_bit,
   input logic              rst,
   input logic [WORD_W-1:0] word_in,
   input logic              aux_pwr,
   input logic              loop_en,
   input logic              ser_out,
   input logic              word_clk,
   input logic              aux_out,
   input logic              aux_active
);
   localparam int CW = (WORD_W > 2) ? $clog2(WORD_W) : 1;

   // independent count of edges since reset, for the word-clock phase
   logic [CW-1:0] ref_ph;
   always_ff @(posedge clk_bit) begin
      if (rst) ref_ph <= '0;
      else     ref_ph <= ref_ph + 1'b1;
   end

   assert_reset_state_R4: assert property (@(posedge clk_bit)
      rst |=> (ser_out == 1'b0) && word_clk);

   assert_wclk_phase_R3: assert property (@(posedge clk_bit) disable iff (rst)
      word_clk == (int'(ref_ph) < WORD_W / 2));

   // load edge: word clock high now and one cycle back, low two cycles back
   assert_msb_first_R1: assert property (@(posedge clk_bit) disable iff (rst)
      (word_clk && $past(word_clk) && !$past(word_clk, 2))
         |-> ser_out == $past(word_in[WORD_W-1]));

   assert_aux_off_R5: assert property (@(posedge clk_bit) disable iff (rst)
      !aux_pwr |-> (!aux_out && !aux_active));

   assert_aux_wclk_R6: assert property (@(posedge clk_bit) disable iff (rst)
      (aux_pwr && !loop_en) |-> (aux_active && aux_out == word_clk));

   assert_aux_loop_R7: assert property (@(posedge clk_bit) disable iff (rst)
      (aux_pwr && loop_en) |-> (aux_active && aux_out == ser_out));
endmodule

bind ser4_tx ser4_tx_chk #(.WORD_W(WORD_W)) u_chk (
   .clk_bit    (clk_bit),
   .rst        (rst),
   .word_in    (word_in),
   .aux_pwr    (aux_pwr),
   .loop_en    (loop_en),
   .ser_out    (ser_out),
   .word_clk   (word_clk),
   .aux_out    (aux_out),
   .aux_active (aux_active)
);

// File: tb/tb_ser4_tx.sv
module tb_ser4_tx;
   localparam int W = 4;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic         rst, aux_pwr, loop_en;
   logic [W-1:0] word_in;
   logic [1:0]   clk_mode;
   logic         ser_out, ser_clk_out, word_clk, aux_out, aux_active;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   ser4_tx #(.WORD_W(W)) dut (
      .clk_bit(clk), .rst(rst), .word_in(word_in), .aux_pwr(aux_pwr),
      .loop_en(loop_en), .clk_mode(clk_mode), .ser_out(ser_out),
      .ser_clk_out(ser_clk_out), .word_clk(word_clk), .aux_out(aux_out),
      .aux_active(aux_active)
   );

   // {word, junk word driven between load edges, aux power, loop enable}
   localparam logic [9:0] VEC [8] = '{
      {4'b1000, 4'b0111, 1'b1, 1'b1},
      {4'b0001, 4'b1110, 1'b1, 1'b1},
      {4'b1010, 4'b0101, 1'b1, 1'b0},
      {4'b0101, 4'b1010, 1'b0, 1'b1},
      {4'b1111, 4'b0000, 1'b0, 1'b0},
      {4'b0000, 4'b1111, 1'b1, 1'b1},
      {4'b1100, 4'b0011, 1'b1, 1'b0},
      {4'b0110, 4'b1001, 1'b1, 1'b1}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic chk_aux(input logic exp_ser, input logic exp_wclk);
      if (!aux_pwr) begin
         chk("R5 aux_out", aux_out, 0);
         chk("R5 aux_active", aux_active, 0);
      end else if (loop_en) begin
         chk("R7 aux_out", aux_out, exp_ser);
         chk("R7 aux_active", aux_active, 1);
      end else begin
         chk("R6 aux_out", aux_out, exp_wclk);
         chk("R6 aux_active", aux_active, 1);
      end
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; word_in = '0; aux_pwr = 1'b1; loop_en = 1'b0; clk_mode = 2'b11;
      repeat (3) @(negedge clk);
      chk("R4 ser_out in reset", ser_out, 0);
      chk("R4 word_clk in reset", word_clk, 1);
      chk("R6 aux in reset", aux_out, 1);

      rst = 1'b0;
      word_in = VEC[0][9:6]; aux_pwr = VEC[0][1]; loop_en = VEC[0][0];
      for (int i = 0; i < 8; i++) begin
         for (int b = 0; b < 4; b++) begin
            logic es, ew;
            int n;
            @(negedge clk);
            n  = 4 * i + b + 1;
            es = VEC[i][9-b];
            ew = (n % 4) < 2;
            chk((b == 0) ? "R1 msb after load" : "R1/R2 serial bit", ser_out, es);
            chk("R3 word_clk", word_clk, ew);
            chk_aux(es, ew);
            if (b == 1) word_in = VEC[i][5:2];
            if (b == 3 && i < 7) begin
               word_in = VEC[i+1][9:6]; aux_pwr = VEC[i+1][1]; loop_en = VEC[i+1][0];
            end
         end
      end

      // reset in mid-stream, then restart
      rst = 1'b1; word_in = 4'b0110;
      @(negedge clk);
      chk("R4 ser_out after reset", ser_out, 0);
      chk("R4 word_clk after reset", word_clk, 1);
      @(negedge clk);
      rst = 1'b0; word_in = 4'b1001; aux_pwr = 1'b1; loop_en = 1'b1;
      for (int b = 0; b < 4; b++) begin
         logic exp_bit;
         exp_bit = (b == 0 || b == 3);
         @(negedge clk);
         if (b == 1) word_in = 4'b0110;
         chk("R2 first word after reset", ser_out, exp_bit);
         chk("R3 word_clk after reset", word_clk, ((b + 1) % 4) < 2);
         chk("R7 loop after reset", aux_out, exp_bit);
      end

      // serial clock gating by strap code
      for (int m = 0; m < 4; m++) begin
         clk_mode = 2'(m);
         @(posedge clk); #2;
         chk("R8 ser_clk_out high phase", ser_clk_out, (m == 0 || m == 3));
         @(negedge clk); #2;
         chk("R8 ser_clk_out low phase", ser_clk_out, 0);
      end

      // powering down overrides loopback
      aux_pwr = 1'b0; loop_en = 1'b1;
      @(negedge clk);
      chk("R5 power-down over loopback", aux_out, 0);
      chk("R5 active off", aux_active, 0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule